// File: doc/BRIEF.md
# Staged Power Throttle for Thread Fetch and Speculation

This controller caps a multithreaded core's power by cutting back work in stages. A power estimator delivers a sample now and then, marked by a one-cycle valid strobe. The controller compares each sample with four thresholds, each a fixed-point fraction of a programmable target power. From the result it drives one branch-prediction enable and one fetch enable per hardware thread. Between samples the enables hold their values. Reset leaves every thread fetching with prediction on.

There are two throttle modes.

- **Hysteresis mode** acts on all threads together and moves through three states:
  - FULL: prediction on, fetch on.
  - NOSPEC: prediction off, fetch on.
  - HALT: prediction off, fetch off.

  Separate entry and exit conditions stop the controller from chattering around a threshold.
- **Incremental mode** scales back one thread per threshold, starting with the thread that ranks lowest in IPC. It uses the states FULL, STEP1, STEP2, STEP3 and HALT, and has no hysteresis.

Top module: `fthr_top`

## Requirements
- R1: After reset, and until the first valid sample, every bit of `bp_en` and `fetch_en` is 1.
- R2: The state and the outputs change only on a cycle where `sample_valid` is 1, and the new outputs appear on the following cycle. Changes to `power_est`, `mode_incr` or `ipc_rank` while `sample_valid` is 0 have no effect on the outputs.
- R3: Threshold k is `(target_pwr * f_k) >> 7`, where f_k is the 8-bit unsigned field `step_frac[8k+7:8k]` and 128 stands for 100%. The fields must be ordered f0 <= f1 <= f2 <= f3; the intended values are 80%, 90%, 100% and 110%. Threshold 1 serves as the lower level and threshold 3 as the upper level.
- R4: In hysteresis mode (`mode_incr`=0), a sample taken in FULL moves to NOSPEC when it is greater than the lower level and not greater than the upper level. In NOSPEC, every `bp_en` is 0 and every `fetch_en` is 1.
- R5: In hysteresis mode, a sample greater than the upper level moves to HALT from any state, including directly from FULL. In HALT, all enables are 0.
- R6: In hysteresis mode, a sample taken in HALT moves to NOSPEC when it is less than the upper level, even if it is also below the lower level. A sample equal to the upper level keeps HALT.
- R7: In hysteresis mode, a sample taken in NOSPEC returns to FULL only when it is less than the lower level. A sample equal to the lower level keeps NOSPEC.
- R8: In incremental mode (`mode_incr`=1), the level L is the number of thresholds 0 to 2 that the sample is greater than or equal to (states FULL, STEP1, STEP2, STEP3 for L = 0 to 3). A thread whose rank in `ipc_rank[2t+1:2t]` is less than L has both of its enables at 0; every other thread has both at 1. Rank 0 is the lowest IPC, and the ranks must form a permutation.
- R9: In incremental mode, a sample greater than or equal to threshold 3 moves to HALT, with all enables 0.
- R10: In incremental mode, each sample sets the state from that sample alone, so any state can be followed directly by any other.
- R11: In hysteresis mode, the states STEP1 to STEP3 (left over after a mode change) behave as NOSPEC. A `bp_en` bit is never 1 while the matching `fetch_en` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Strobe that marks a new power sample |
| power_est | input | PWR_W | Power estimate |
| mode_incr | input | 1 | 0 selects hysteresis mode, 1 selects incremental mode |
| target_pwr | input | PWR_W | Target power |
| step_frac | input | 4*FRAC_W | Four threshold fractions, Q1.7 |
| ipc_rank | input | N_THREADS*RANK_W | Per-thread IPC rank, 0 = lowest |
| bp_en | output | N_THREADS | Per-thread branch-prediction enable |
| fetch_en | output | N_THREADS | Per-thread fetch enable |

## Verification
Two pairs of events can land on the same sample, and the bench provokes both.

- **Both levels crossed at once.** A single sample jumps from below the lower level to above the upper level. The bench expects the controller to go straight from FULL to HALT, with no NOSPEC cycle in between. The reverse case is also driven: a low sample taken in HALT must stop at NOSPEC rather than return to FULL.
- **Rank update with a sample.** A new `ipc_rank` is presented on the same cycle as a sample. It is judged by which thread's enables drop one cycle later.
- **Rank update without a sample.** A rank change with no strobe is judged by the outputs staying unchanged.

// File: rtl/fthr_pkg.sv
package fthr_pkg;

    localparam int NUM_LEVELS = 4;

    typedef enum logic [2:0] {
        ST_FULL   = 3'd0,
        ST_NOSPEC = 3'd1,
        ST_HALT   = 3'd2,
        ST_STEP1  = 3'd3,
        ST_STEP2  = 3'd4,
        ST_STEP3  = 3'd5
    } thr_state_e;

endpackage

// File: rtl/fthr_scaler.sv
module fthr_scaler #(
    parameter int PWR_W      = 16,
    parameter int FRAC_W     = 8,
    parameter int FRAC_SHIFT = 7,
    parameter int NLVL       = 4,
    localparam int THR_W     = PWR_W + FRAC_W - FRAC_SHIFT,
    localparam int PROD_W    = PWR_W + FRAC_W
) (
    input  logic [PWR_W-1:0]       target_pwr,
    input  logic [NLVL*FRAC_W-1:0] step_frac,
    output logic [NLVL*THR_W-1:0]  thr_flat
);

    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        logic [PROD_W-1:0] prod;
        always_comb begin
            prod = PROD_W'(target_pwr) * PROD_W'(step_frac[k*FRAC_W +: FRAC_W]);
        end
        assign thr_flat[k*THR_W +: THR_W] = prod[PROD_W-1:FRAC_SHIFT];
    end

endmodule

// File: rtl/fthr_compare.sv
module fthr_compare #(
    parameter int PWR_W = 16,
    parameter int THR_W = 17,
    parameter int NLVL  = 4
) (
    input  logic [PWR_W-1:0]      power_est,
    input  logic [NLVL*THR_W-1:0] thr_flat,
    output logic [NLVL-1:0]       ge_thr,
    output logic [NLVL-1:0]       gt_thr
);

    logic [THR_W-1:0] pw_ext;
    assign pw_ext = THR_W'(power_est);

    for (genvar k = 0; k < NLVL; k++) begin : g_cmp
        assign ge_thr[k] = (pw_ext >= thr_flat[k*THR_W +: THR_W]);
        assign gt_thr[k] = (pw_ext >  thr_flat[k*THR_W +: THR_W]);
    end

endmodule

// File: rtl/fthr_fsm.sv
module fthr_fsm
    import fthr_pkg::*;
#(
    parameter int NLVL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_valid,
    input  logic            mode_incr,
    input  logic [NLVL-1:0] ge_thr,
    input  logic [NLVL-1:0] gt_thr,
    output thr_state_e      state_q,
    output thr_state_e      state_d
);

    localparam int LO = 1;
    localparam int HI = NLVL - 1;

    thr_state_e hyst_next;
    thr_state_e incr_next;

    // hysteresis mode transitions
    always_comb begin
        hyst_next = state_q;
        unique case (state_q)
            ST_FULL: begin
                if (gt_thr[HI])      hyst_next = ST_HALT;
                else if (gt_thr[LO]) hyst_next = ST_NOSPEC;
                else                 hyst_next = ST_FULL;
            end
            ST_HALT: begin
                if (!ge_thr[HI])     hyst_next = ST_NOSPEC;
                else                 hyst_next = ST_HALT;
            end
            ST_NOSPEC, ST_STEP1, ST_STEP2, ST_STEP3: begin
                if (gt_thr[HI])      hyst_next = ST_HALT;
                else if (!ge_thr[LO]) hyst_next = ST_FULL;
                else                 hyst_next = ST_NOSPEC;
            end
            default:                 hyst_next = ST_FULL;
        endcase
    end

    // incremental mode: level from this sample only
    always_comb begin
        if (ge_thr[3])      incr_next = ST_HALT;
        else if (ge_thr[2]) incr_next = ST_STEP3;
        else if (ge_thr[1]) incr_next = ST_STEP2;
        else if (ge_thr[0]) incr_next = ST_STEP1;
        else                incr_next = ST_FULL;
    end

    always_comb begin
        if (!sample_valid)  state_d = state_q;
        else if (mode_incr) state_d = incr_next;
        else                state_d = hyst_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FULL;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/fthr_outmap.sv
module fthr_outmap
    import fthr_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int RANK_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_valid,
    input  thr_state_e                  state_d,
    input  logic [N_THREADS*RANK_W-1:0] ipc_rank,
    output logic [N_THREADS-1:0]        bp_en,
    output logic [N_THREADS-1:0]        fetch_en
);

    localparam int LVL_W = RANK_W + 1;

    logic [LVL_W-1:0]     level;
    logic                 all_halt;
    logic                 no_spec;
    logic [N_THREADS-1:0] bp_nx;
    logic [N_THREADS-1:0] fe_nx;

    always_comb begin
        level    = '0;
        all_halt = 1'b0;
        no_spec  = 1'b0;
        unique case (state_d)
            ST_FULL:   level = LVL_W'(0);
            ST_STEP1:  level = LVL_W'(1);
            ST_STEP2:  level = LVL_W'(2);
            ST_STEP3:  level = LVL_W'(3);
            ST_NOSPEC: no_spec = 1'b1;
            ST_HALT:   all_halt = 1'b1;
            default:   all_halt = 1'b1;
        endcase
    end

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        logic thr_cut;
        assign thr_cut  = (LVL_W'(ipc_rank[t*RANK_W +: RANK_W]) < level);
        assign fe_nx[t] = !(all_halt || thr_cut);
        assign bp_nx[t] = !(all_halt || thr_cut || no_spec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_en    <= '1;
            fetch_en <= '1;
        end else if (sample_valid) begin
            bp_en    <= bp_nx;
            fetch_en <= fe_nx;
        end
    end

endmodule

// File: rtl/fthr_top.sv
module fthr_top
    import fthr_pkg::*;
#(
    parameter int PWR_W      = 16,
    parameter int FRAC_W     = 8,
    parameter int FRAC_SHIFT = 7,
    parameter int N_THREADS  = 4,
    localparam int RANK_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int THR_W     = PWR_W + FRAC_W - FRAC_SHIFT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_valid,
    input  logic [PWR_W-1:0]              power_est,
    input  logic                          mode_incr,
    input  logic [PWR_W-1:0]              target_pwr,
    input  logic [NUM_LEVELS*FRAC_W-1:0]  step_frac,
    input  logic [N_THREADS*RANK_W-1:0]   ipc_rank,
    output logic [N_THREADS-1:0]          bp_en,
    output logic [N_THREADS-1:0]          fetch_en
);

    logic [NUM_LEVELS*THR_W-1:0] thr_flat;
    logic [NUM_LEVELS-1:0]       ge_thr;
    logic [NUM_LEVELS-1:0]       gt_thr;
    thr_state_e                  state_q;
    thr_state_e                  state_d;

    fthr_scaler #(
        .PWR_W(PWR_W), .FRAC_W(FRAC_W), .FRAC_SHIFT(FRAC_SHIFT), .NLVL(NUM_LEVELS)
    ) u_scaler (
        .target_pwr(target_pwr),
        .step_frac (step_frac),
        .thr_flat  (thr_flat)
    );

    fthr_compare #(
        .PWR_W(PWR_W), .THR_W(THR_W), .NLVL(NUM_LEVELS)
    ) u_compare (
        .power_est(power_est),
        .thr_flat (thr_flat),
        .ge_thr   (ge_thr),
        .gt_thr   (gt_thr)
    );

    fthr_fsm #(
        .NLVL(NUM_LEVELS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .mode_incr   (mode_incr),
        .ge_thr      (ge_thr),
        .gt_thr      (gt_thr),
        .state_q     (state_q),
        .state_d     (state_d)
    );

    fthr_outmap #(
        .N_THREADS(N_THREADS), .RANK_W(RANK_W)
    ) u_outmap (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .state_d     (state_d),
        .ipc_rank    (ipc_rank),
        .bp_en       (bp_en),
        .fetch_en    (fetch_en)
    );

endmodule

// File: rtl/fthr_checker.sv
module fthr_checker #(
    parameter int PWR_W     = 16,
    parameter int THR_W     = 17,
    parameter int N_THREADS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sample_valid,
    input logic                   mode_incr,
    input logic [PWR_W-1:0]       power_est,
    input logic [4*THR_W-1:0]     thr_flat,
    input logic [N_THREADS-1:0]   bp_en,
    input logic [N_THREADS-1:0]   fetch_en
);

    logic [THR_W-1:0] pw;
    logic [THR_W-1:0] t0;
    logic [THR_W-1:0] t1;
    logic [THR_W-1:0] t3;
    assign pw = THR_W'(power_est);
    assign t0 = thr_flat[0*THR_W +: THR_W];
    assign t1 = thr_flat[1*THR_W +: THR_W];
    assign t3 = thr_flat[3*THR_W +: THR_W];

    // R2
    hold_between_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(bp_en) && $stable(fetch_en)));

    // R4
    spec_off_above_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !mode_incr && pw > t1) |=> (bp_en == '0));

    // R5
    halt_above_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !mode_incr && pw > t3) |=> (fetch_en == '0 && bp_en == '0));

    // R6
    resume_no_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !mode_incr && fetch_en == '0 && pw < t3 && pw >= t1)
        |=> (fetch_en == '1 && bp_en == '0));

    // R9
    incr_top_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && mode_incr && pw >= t3) |=> (fetch_en == '0));

    // R10
    incr_low_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && mode_incr && pw < t0) |=> (fetch_en == '1 && bp_en == '1));

    // R11
    bp_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bp_en & ~fetch_en) == '0));

endmodule

bind fthr_top fthr_checker #(
    .PWR_W(PWR_W), .THR_W(THR_W), .N_THREADS(N_THREADS)
) u_fthr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .mode_incr   (mode_incr),
    .power_est   (power_est),
    .thr_flat    (thr_flat),
    .bp_en       (bp_en),
    .fetch_en    (fetch_en)
);

// File: tb/fthr_top_test.sv
module fthr_top_test;

    localparam int NVEC = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] power_est = '0;
    logic        mode_incr = 1'b0;
    logic [15:0] target_pwr = 16'd1000;
    // f3=141 (~110%), f2=128, f1=115 (~90%), f0=102 (~80%) -> 1101, 1000, 898, 796
    logic [31:0] step_frac = {8'd141, 8'd128, 8'd115, 8'd102};
    // ranks: t0=2, t1=0, t2=3, t3=1
    logic [7:0]  ipc_rank = {2'd1, 2'd3, 2'd0, 2'd2};
    logic [3:0]  bp_en;
    logic [3:0]  fetch_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fthr_top uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .power_est(power_est), .mode_incr(mode_incr), .target_pwr(target_pwr),
        .step_frac(step_frac), .ipc_rank(ipc_rank),
        .bp_en(bp_en), .fetch_en(fetch_en)
    );

    // {mode, power, expected bp_en, expected fetch_en}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 16'd500,  4'hF, 4'hF},
        {1'b0, 16'd898,  4'hF, 4'hF},
        {1'b0, 16'd899,  4'h0, 4'hF},
        {1'b0, 16'd898,  4'h0, 4'hF},
        {1'b0, 16'd1101, 4'h0, 4'hF},
        {1'b0, 16'd1102, 4'h0, 4'h0},
        {1'b0, 16'd1101, 4'h0, 4'h0},
        {1'b0, 16'd1100, 4'h0, 4'hF},
        {1'b0, 16'd897,  4'hF, 4'hF},
        {1'b0, 16'd1200, 4'h0, 4'h0},
        {1'b0, 16'd100,  4'h0, 4'hF},
        {1'b0, 16'd100,  4'hF, 4'hF},
        {1'b1, 16'd795,  4'hF, 4'hF},
        {1'b1, 16'd796,  4'hD, 4'hD},
        {1'b1, 16'd898,  4'h5, 4'h5},
        {1'b1, 16'd999,  4'h5, 4'h5},
        {1'b1, 16'd1000, 4'h4, 4'h4},
        {1'b1, 16'd1101, 4'h0, 4'h0},
        {1'b1, 16'd700,  4'hF, 4'hF},
        {1'b1, 16'd1000, 4'h4, 4'h4},
        {1'b0, 16'd898,  4'h0, 4'hF},
        {1'b0, 16'd897,  4'hF, 4'hF}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1:           return "R3/R4";
            2:              return "R4";
            3, 4, 8, 11:    return "R7";
            5, 9:           return "R5";
            6, 7, 10:       return "R6";
            12, 13, 14, 15, 16: return "R8";
            17:             return "R9";
            18, 19:         return "R10";
            default:        return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic sample(logic m, logic [15:0] p);
        @(negedge clk);
        mode_incr = m;
        power_est = p;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "bp_en after reset", bp_en, 4'hF);
        check("R1", "fetch_en after reset", fetch_en, 4'hF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "bp_en before first sample", bp_en, 4'hF);

        for (int i = 0; i < NVEC; i++) begin
            sample(VEC[i][24], VEC[i][23:8]);
            check(vec_req(i), $sformatf("vector %0d bp_en", i), bp_en, VEC[i][7:4]);
            check(vec_req(i), $sformatf("vector %0d fetch_en", i), fetch_en, VEC[i][3:0]);
        end

        // R2: inputs change without strobe -> outputs held
        @(negedge clk);
        mode_incr = 1'b1;
        power_est = 16'd1200;
        ipc_rank = {2'd3, 2'd2, 2'd1, 2'd0};
        repeat (3) @(negedge clk);
        check("R2", "bp_en held without strobe", bp_en, 4'hF);
        check("R2", "fetch_en held without strobe", fetch_en, 4'hF);

        // R8: new ranks used with the sample (t0 now lowest)
        sample(1'b1, 16'd800);
        check("R8", "rank update bp_en", bp_en, 4'hE);
        check("R8", "rank update fetch_en", fetch_en, 4'hE);

        // R2: output latency is one cycle after strobe
        @(negedge clk);
        mode_incr = 1'b0;
        power_est = 16'd1150;
        sample_valid = 1'b1;
        check("R2", "no change in strobe cycle", fetch_en, 4'hE);
        @(negedge clk);
        sample_valid = 1'b0;
        check("R5", "halt one cycle after strobe", fetch_en, 4'h0);

        // R3: new target rescales thresholds (target 2000 -> lower 1796)
        target_pwr = 16'd2000;
        sample(1'b0, 16'd1500);
        check("R6", "halt to nospec at new target", fetch_en, 4'hF);
        sample(1'b0, 16'd1796);
        check("R3", "equal to scaled lower keeps nospec", bp_en, 4'h0);
        sample(1'b0, 16'd1795);
        check("R3", "below scaled lower returns full", bp_en, 4'hF);

        finish_run();
    end

endmodule